// File: doc/BRIEF.md
# General-Purpose Capture/Compare Timer

This block is a 32-bit timer for software use. It has an up-counter that moves on each cycle where the clock-enable input is high and the run bit is set. Three kinds of event can occur:

- **Overflow:** the counter wraps past all-ones. It then either reloads a programmed value and keeps running, or stops (one-shot).
- **Compare match:** the counter takes a value equal to the compare register.
- **Capture:** a selected edge on a synchronized capture pin copies the current count into a capture register.

Each event sets its own status flag. Software clears a flag by writing 1 to it. The enabled flags are ORed onto one interrupt line. A trigger output is built from the overflow and compare events. It works either as a PWM wave or as a toggle, and it has a polarity control.

All registers sit on a simple word-addressed port: a write strobe, an address, write data, and registered read data. The counter, reload and compare registers can be rewritten while the timer counts.

Register map (word addresses):

| Address | Register | Content |
|---|---|---|
| 0 | Control | bit0 run, bit1 auto-reload, bits3:2 capture edge select, bit4 output mode, bit5 polarity |
| 1 | Count | counter value |
| 2 | Reload | reload value |
| 3 | Compare | compare value |
| 4 | Capture | captured count (read-only) |
| 5 | Status | bit0 overflow, bit1 compare, bit2 capture |
| 6 | Enable | interrupt enables, same bit layout as Status |
| 7 | — | unused, reads 0 |

Top module: `gp_capcmp_timer`

## Requirements
- R1: While control bit0 (run) is 1 and `tick_en` is 1, the count rises by one at each clock edge. Otherwise the count holds.
- R2: A tick taken at count 0xFFFFFFFF is an overflow. With auto-reload off (control bit1 = 0) the count becomes 0. Every overflow sets status bit0.
- R3: With auto-reload on (control bit1 = 1), an overflow loads the Reload register into the count, and the run bit stays 1.
- R4: With auto-reload off, an overflow clears the run bit, and counting stops until software sets it again. A Control write in the same cycle takes priority.
- R5: When a tick leaves the count equal to the Compare register, status bit1 is set.
- R6: The capture pin passes through a two-stage synchronizer. Edge select is control bits3:2: 00 none, 01 rising, 10 falling, 11 both. A selected edge seen on the synchronized pin stores the count of that cycle in Capture and sets status bit2. The capture register is written at the third clock edge after the pin changes. Edges that are not selected leave Capture and status unchanged.
- R7: With control bit4 = 1 (PWM), the internal level is set by an overflow and cleared by a compare match; the match wins if both occur in the same cycle. With bit4 = 0 (toggle), the level inverts on a cycle with either event. `trig_out` is that level XOR control bit5, and it is registered.
- R8: A write to Count in a cycle with a tick loads the written value. That cycle produces no overflow and no compare event.
- R9: Writing 1 to a status bit clears it. An event in the same cycle wins over the clear. `irq` is the registered OR of Status AND Enable, so it follows one cycle after those registers.
- R10: `reg_rdata` shows, one clock after `reg_addr`, the register at that address as listed in the map. Address 7 reads 0.
- R11: After reset, every register, `trig_out` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable, one count per high cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| cap_in | input | 1 | Asynchronous capture input |
| trig_out | output | 1 | Trigger / PWM output |
| irq | output | 1 | Interrupt request |

## Verification
Timing of each result:

- Count, status, control and the trigger output change at the same edge as the tick or write that causes them.
- Read data appears one edge after its address.
- `irq` appears one edge after the status and enable registers.
- Captures land three edges after the pin moves.

A behavioural model in the bench advances at every rising edge with the same inputs as the design, and it models these delays exactly. The design's outputs are compared with the model at the following falling edge. Directed checks read registers with the tick held low, so each expected value is a fixed number known from the requirement.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned A_CTRL    = 0;
  localparam int unsigned A_COUNT   = 1;
  localparam int unsigned A_RELOAD  = 2;
  localparam int unsigned A_COMPARE = 3;
  localparam int unsigned A_CAPTURE = 4;
  localparam int unsigned A_STATUS  = 5;
  localparam int unsigned A_IRQEN   = 6;

  localparam int unsigned EV_N   = 3;
  localparam int unsigned EV_OVF = 0;
  localparam int unsigned EV_CMP = 1;
  localparam int unsigned EV_CAP = 2;

  typedef struct packed {
    logic       pol;
    logic       pwm;
    logic [1:0] edge_sel;
    logic       autoreload;
    logic       run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         run,
  input  logic         autoreload,
  input  logic [W-1:0] reload,
  input  logic [W-1:0] compare,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic         ovf_evt,
  output logic         cmp_evt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d   = cnt;
    ovf_evt = 1'b0;
    cmp_evt = 1'b0;
    if (wr) begin
      cnt_d = wdata;
    end else if (run && tick) begin
      if (&cnt) begin
        ovf_evt = 1'b1;
        cnt_d   = autoreload ? reload : '0;
      end else begin
        cnt_d = cnt + W'(1);
      end
      cmp_evt = (cnt_d == compare);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_d;
  end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int unsigned W     = 32,
  parameter int unsigned SYNC_N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_in,
  input  logic [1:0]   edge_sel,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cap_q,
  output logic         cap_evt
);
  logic [SYNC_N-1:0] sync_q;
  logic              hist_q;
  logic              s_now;

  generate
    if (SYNC_N == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= cap_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_N-2:0], cap_in};
      end
    end
  endgenerate

  assign s_now   = sync_q[SYNC_N-1];
  assign cap_evt = (edge_sel[0] & s_now & ~hist_q) |
                   (edge_sel[1] & ~s_now & hist_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      hist_q <= s_now;
      if (cap_evt) cap_q <= cnt;
    end
  end
endmodule

// File: rtl/tmr_outgen.sv
module tmr_outgen (
  input  logic clk,
  input  logic rst,
  input  logic pwm,
  input  logic pol,
  input  logic ovf_evt,
  input  logic cmp_evt,
  output logic trig_out
);
  logic raw_q, raw_d;

  always_comb begin
    raw_d = raw_q;
    if (pwm) begin
      if (cmp_evt)      raw_d = 1'b0;
      else if (ovf_evt) raw_d = 1'b1;
    end else if (ovf_evt || cmp_evt) begin
      raw_d = ~raw_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q    <= 1'b0;
      trig_out <= 1'b0;
    end else begin
      raw_q    <= raw_d;
      trig_out <= raw_d ^ pol;
    end
  end
endmodule

// File: rtl/gp_capcmp_timer.sv
module gp_capcmp_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic              cap_in,
  output logic              trig_out,
  output logic              irq
);
  ctrl_t           ctrl_q;
  logic [W-1:0]    reload_q, compare_q, cnt, cap_q;
  logic [EV_N-1:0] status_q, irqen_q, events, clr_mask;
  logic            ovf_evt, cmp_evt, cap_evt;
  logic            ctrl_wr, cnt_wr, rel_wr, cmp_wr, st_wr, en_wr;
  logic [W-1:0]    rd_d;

  assign ctrl_wr = reg_we && (reg_addr == ADDR_W'(A_CTRL));
  assign cnt_wr  = reg_we && (reg_addr == ADDR_W'(A_COUNT));
  assign rel_wr  = reg_we && (reg_addr == ADDR_W'(A_RELOAD));
  assign cmp_wr  = reg_we && (reg_addr == ADDR_W'(A_COMPARE));
  assign st_wr   = reg_we && (reg_addr == ADDR_W'(A_STATUS));
  assign en_wr   = reg_we && (reg_addr == ADDR_W'(A_IRQEN));

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_en), .run(ctrl_q.run),
    .autoreload(ctrl_q.autoreload), .reload(reload_q), .compare(compare_q),
    .wr(cnt_wr), .wdata(reg_wdata), .cnt(cnt),
    .ovf_evt(ovf_evt), .cmp_evt(cmp_evt)
  );

  tmr_capture #(.W(W), .SYNC_N(SYNC_N)) u_cap (
    .clk(clk), .rst(rst), .cap_in(cap_in), .edge_sel(ctrl_q.edge_sel),
    .cnt(cnt), .cap_q(cap_q), .cap_evt(cap_evt)
  );

  tmr_outgen u_out (
    .clk(clk), .rst(rst), .pwm(ctrl_q.pwm), .pol(ctrl_q.pol),
    .ovf_evt(ovf_evt), .cmp_evt(cmp_evt), .trig_out(trig_out)
  );

  always_comb begin
    events         = '0;
    events[EV_OVF] = ovf_evt;
    events[EV_CMP] = cmp_evt;
    events[EV_CAP] = cap_evt;
    clr_mask       = st_wr ? reg_wdata[EV_N-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      reload_q  <= '0;
      compare_q <= '0;
      status_q  <= '0;
      irqen_q   <= '0;
      irq       <= 1'b0;
    end else begin
      if (ctrl_wr)                             ctrl_q     <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      else if (ovf_evt && !ctrl_q.autoreload) ctrl_q.run <= 1'b0;
      if (rel_wr) reload_q  <= reg_wdata;
      if (cmp_wr) compare_q <= reg_wdata;
      if (en_wr)  irqen_q   <= reg_wdata[EV_N-1:0];
      status_q <= (status_q & ~clr_mask) | events;
      irq      <= |(status_q & irqen_q);
    end
  end

  always_comb begin
    rd_d = '0;
    case (reg_addr)
      ADDR_W'(A_CTRL):    rd_d = {{(W-CTRL_W){1'b0}}, ctrl_q};
      ADDR_W'(A_COUNT):   rd_d = cnt;
      ADDR_W'(A_RELOAD):  rd_d = reload_q;
      ADDR_W'(A_COMPARE): rd_d = compare_q;
      ADDR_W'(A_CAPTURE): rd_d = cap_q;
      ADDR_W'(A_STATUS):  rd_d = {{(W-EV_N){1'b0}}, status_q};
      ADDR_W'(A_IRQEN):   rd_d = {{(W-EV_N){1'b0}}, irqen_q};
      default:            rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         run,
  input logic         autoreload,
  input logic         ctrl_wr,
  input logic         cnt_wr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cnt,
  input logic [W-1:0] reload,
  input logic [W-1:0] cap_q,
  input logic         ovf_evt,
  input logic         cmp_evt,
  input logic         cap_evt,
  input logic [2:0]   status,
  input logic [2:0]   irqen,
  input logic         irq
);
  // R1: one step per enabled tick
  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !cnt_wr && !(&cnt)) |=> (cnt == $past(cnt) + W'(1)));
  // R1: hold when not ticking
  a_r1_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && !(run && tick)) |=> $stable(cnt));
  // R3: reload on overflow
  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && autoreload) |=> (cnt == $past(reload) && run));
  // R4: one-shot halts
  a_r4_oneshot_halt: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !autoreload && !ctrl_wr) |=> !run);
  // R8: software write wins with no event
  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt == $past(wdata)));
  a_r8_no_event: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |-> (!ovf_evt && !cmp_evt));
  // R6: capture stores count
  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (cap_q == $past(cnt) && status[2]));
  // R9: interrupt follows enabled flags
  a_r9_irq_raise: assert property (@(posedge clk) disable iff (rst)
    ((status & irqen) != 3'b0) |=> irq);
  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((status & irqen) == 3'b0) |=> !irq);
endmodule

bind gp_capcmp_timer tmr_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_en), .run(ctrl_q.run),
  .autoreload(ctrl_q.autoreload), .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr),
  .wdata(reg_wdata), .cnt(cnt), .reload(reload_q), .cap_q(cap_q),
  .ovf_evt(ovf_evt), .cmp_evt(cmp_evt), .cap_evt(cap_evt),
  .status(status_q), .irqen(irqen_q), .irq(irq)
);

// File: tb/sim_gp_capcmp_timer.sv
`timescale 1ns/1ps
module sim_gp_capcmp_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0, reg_we = 1'b0, cap_in = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        trig_out, irq;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gp_capcmp_timer u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_in(cap_in), .trig_out(trig_out), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_cnt, m_rel, m_cmp, m_cap, e_rdata;
  logic [5:0]  m_ctrl;
  logic [2:0]  m_st, m_en, m_aq;
  logic        m_raw, m_s1, m_s2, m_s3, e_trig, e_irq, mon = 1'b0;

  always @(posedge clk) begin : model
    logic [31:0] nc;
    logic ov, cm, cp, nraw;
    logic [2:0] clr;
    if (rst) begin
      m_cnt = 0; m_rel = 0; m_cmp = 0; m_cap = 0; m_ctrl = 0; m_st = 0; m_en = 0;
      m_raw = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      e_rdata = 0; e_trig = 0; e_irq = 0; m_aq = 0; mon = 1'b1;
    end else begin
      e_irq = |(m_st & m_en);
      case (reg_addr)
        3'd0: e_rdata = {26'd0, m_ctrl};
        3'd1: e_rdata = m_cnt;
        3'd2: e_rdata = m_rel;
        3'd3: e_rdata = m_cmp;
        3'd4: e_rdata = m_cap;
        3'd5: e_rdata = {29'd0, m_st};
        3'd6: e_rdata = {29'd0, m_en};
        default: e_rdata = 0;
      endcase
      ov = 0; cm = 0; nc = m_cnt;
      if (reg_we && reg_addr == 3'd1) nc = reg_wdata;
      else if (m_ctrl[0] && tick_en) begin
        if (m_cnt == 32'hFFFF_FFFF) begin ov = 1; nc = m_ctrl[1] ? m_rel : 32'd0; end
        else nc = m_cnt + 1;
        cm = (nc == m_cmp);
      end
      cp = (m_ctrl[2] && m_s2 && !m_s3) || (m_ctrl[3] && !m_s2 && m_s3);
      if (cp) m_cap = m_cnt;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
      nraw = m_raw;
      if (m_ctrl[4]) begin
        if (cm) nraw = 0; else if (ov) nraw = 1;
      end else if (ov || cm) nraw = !m_raw;
      e_trig = nraw ^ m_ctrl[5];
      m_raw = nraw;
      clr = (reg_we && reg_addr == 3'd5) ? reg_wdata[2:0] : 3'd0;
      m_st = (m_st & ~clr) | {cp, cm, ov};
      if (reg_we && reg_addr == 3'd0) m_ctrl = reg_wdata[5:0];
      else if (ov && !m_ctrl[1]) m_ctrl[0] = 0;
      if (reg_we && reg_addr == 3'd2) m_rel = reg_wdata;
      if (reg_we && reg_addr == 3'd3) m_cmp = reg_wdata;
      if (reg_we && reg_addr == 3'd6) m_en = reg_wdata[2:0];
      m_cnt = nc;
      m_aq = reg_addr;
    end
  end

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R4";
      3'd1: return "R1";
      3'd4: return "R6";
      3'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (mon && !finished) begin
      tests += 3;
      if (reg_rdata !== e_rdata) begin
        fails++;
        $display("FAIL %s model rdata addr=%0d act=%h exp=%h", rd_tag(m_aq), m_aq, reg_rdata, e_rdata);
      end
      if (trig_out !== e_trig) begin
        fails++;
        $display("FAIL R7 model trig_out act=%b exp=%b", trig_out, e_trig);
      end
      if (irq !== e_irq) begin
        fails++;
        $display("FAIL R9 model irq act=%b exp=%b", irq, e_irq);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst = 0;
    // R11 reset state
    rd(3'd1, 32'd0, "R11");
    rd(3'd0, 32'd0, "R11");
    check("R11 trig", {31'd0, trig_out}, 32'd0);
    check("R11 irq", {31'd0, irq}, 32'd0);
    // R10 register readback
    wr(3'd2, 32'h100); rd(3'd2, 32'h100, "R10");
    wr(3'd3, 32'h105); rd(3'd3, 32'h105, "R10");
    rd(3'd7, 32'd0, "R10");
    // R2 / R4 one-shot overflow
    wr(3'd1, 32'hFFFF_FFFD); wr(3'd0, 32'h1);
    tick_en = 1; repeat (6) @(negedge clk); tick_en = 0;
    rd(3'd1, 32'd0, "R2");
    rd(3'd0, 32'd0, "R4");
    rd(3'd5, 32'd1, "R2");
    wr(3'd5, 32'd1); rd(3'd5, 32'd0, "R9");
    // R3 auto-reload
    wr(3'd1, 32'hFFFF_FFFF); wr(3'd0, 32'h3);
    tick_en = 1; @(negedge clk); tick_en = 0;
    rd(3'd1, 32'h100, "R3");
    rd(3'd0, 32'h3, "R3");
    // R5 compare
    tick_en = 1; repeat (5) @(negedge clk); tick_en = 0;
    rd(3'd5, 32'h3, "R5");
    rd(3'd1, 32'h105, "R5");
    // R9 interrupt enable and clear
    wr(3'd6, 32'h2); @(negedge clk);
    check("R9 irq on", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'h3); @(negedge clk);
    check("R9 irq off", {31'd0, irq}, 32'd0);
    // R8 write beats tick
    wr(3'd0, 32'h1); wr(3'd1, 32'hFFFF_FFFF);
    tick_en = 1; reg_we = 1; reg_addr = 3'd1; reg_wdata = 32'h105;
    @(negedge clk); reg_we = 0; tick_en = 0;
    rd(3'd5, 32'd0, "R8");
    rd(3'd1, 32'h105, "R8");
    rd(3'd0, 32'h1, "R8");
    // R6 capture, rising only
    wr(3'd0, 32'h4);
    cap_in = 1; repeat (4) @(negedge clk);
    rd(3'd4, 32'h105, "R6");
    rd(3'd5, 32'h4, "R6");
    wr(3'd1, 32'h77); wr(3'd5, 32'h4);
    cap_in = 0; repeat (4) @(negedge clk);
    rd(3'd5, 32'd0, "R6 falling ignored");
    rd(3'd4, 32'h105, "R6 falling ignored");
    wr(3'd0, 32'h8);
    cap_in = 1; repeat (4) @(negedge clk); cap_in = 0; repeat (4) @(negedge clk);
    rd(3'd4, 32'h77, "R6 falling edge");
    // R7 PWM then toggle with polarity
    wr(3'd1, 32'hFFFF_FFFE); wr(3'd0, 32'h13);
    tick_en = 1; repeat (2) @(negedge clk); tick_en = 0;
    check("R7 pwm set", {31'd0, trig_out}, 32'd1);
    tick_en = 1; repeat (5) @(negedge clk); tick_en = 0;
    check("R7 pwm clear", {31'd0, trig_out}, 32'd0);
    wr(3'd0, 32'h23); @(negedge clk);
    check("R7 polarity", {31'd0, trig_out}, 32'd1);
    // R1 mixed random traffic checked against the model
    r = 32'h1234_5678;
    wr(3'd6, 32'h7);
    for (int i = 0; i < 4000; i++) begin
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      tick_en = r[0] | r[1];
      if (r[9:6] == 4'd0) cap_in = ~cap_in;
      reg_addr = r[12:10];
      reg_we = (r[17:13] == 5'd0);
      case (r[12:10])
        3'd0: reg_wdata = {r[31:26], 26'd0} | 32'h1 | (r[25:18] & 8'h3E);
        3'd1: reg_wdata = 32'hFFFF_FFF0 | r[23:20];
        3'd3: reg_wdata = 32'hFFFF_FFF8 | r[22:20];
        default: reg_wdata = r;
      endcase
      @(negedge clk);
    end
    reg_we = 0; tick_en = 0;
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule